// File: doc/BRIEF.md
# I2C Target with 7-bit and 10-bit Addressing

This block is an I2C target (slave) that runs from a system clock much faster than the bus clock. Both bus lines are oversampled: each passes a two-flop synchronizer and a three-sample majority filter, and the filtered copies are edge-detected. START and STOP conditions are recognised from SDA edges while SCL is high. The block matches either a 7-bit or a 10-bit own address, acknowledges, and then moves data bytes in either direction.

Open-drain drive is modelled as a single pull-low enable on SDA. The enable only moves while SCL is low, a fixed number of system clocks after the filtered SCL falling edge. On the host side, bytes written by the controller appear with a one-cycle valid pulse. Bytes to be read are taken from a host-supplied input, and a one-cycle pulse marks each load.

In 10-bit mode the first byte is a prefix: 11110, then own-address bits 9:8, then R/W. The low address byte follows. A 10-bit read is only accepted after a repeated START that follows a complete 10-bit selection. Own addresses in the reserved 7-bit ranges are never matched.

Top module: `i2c_dual_addr_target`

## Requirements
- R1: After reset `sda_pull_o` and `rx_valid_o` are 0 and the target waits for a START.
- R2: In 7-bit mode (`ten_bit_i`=0), a first byte whose bits 7:1 equal `own_addr_i[6:0]` with bit 0 (R/W)=0 is ACKed by pulling SDA low during the ninth clock. Each following byte is shifted in MSB first, presented on `rx_byte_o` with a one-cycle `rx_valid_o` pulse, and ACKed.
- R3: When the address does not match, the target NACKs (leaves SDA released) and ignores all traffic until the next START or STOP: no ACK and no `rx_valid_o`.
- R4: In 7-bit mode, an own address whose upper four bits are 0000 or 1111 is never matched.
- R5: For a 7-bit read (R/W=1), `tx_byte_i` is sampled at the start of each byte, with a one-cycle `tx_next_o` pulse. The byte is sent MSB first, and pull low means a 0 bit. A controller ACK leads to the next byte.
- R6: A controller NACK after a read byte ends the read. SDA stays released until the next START.
- R7: In 10-bit mode, a first byte of 11110, `own_addr_i[9:8]`, 0 is ACKed, and any other prefix is NACKed. A second byte equal to `own_addr_i[7:0]` is then ACKed, and write data follows as in R2.
- R8: If the second 10-bit address byte differs from `own_addr_i[7:0]`, it is NACKed and the rest of the transfer is ignored.
- R9: A 10-bit prefix with R/W=1 is ACKed only after a repeated START that follows a complete 10-bit selection. The read then proceeds as in R5, and in every other case it is NACKed.
- R10: A STOP returns the target to idle and discards any earlier 10-bit selection.
- R11: `sda_pull_o` changes only while SCL is low.
- R12: A repeated START, without a STOP before it, restarts address matching.
- R13: A low pulse on SCL lasting a single system clock, during a high phase, is filtered out and shifts no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| own_addr_i | input | 10 | Own address (bits 6:0 used in 7-bit mode) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| tx_byte_i | input | 8 | Next byte to send on a read |
| tx_next_o | output | 1 | Pulse: `tx_byte_i` was just loaded |
| rx_byte_o | output | 8 | Last byte written by the controller |
| rx_valid_o | output | 1 | Pulse: `rx_byte_o` holds a new byte |

## Verification
The hardest condition to reach from the ports is an accepted 10-bit read. It needs a full two-byte write selection, then a repeated START with no STOP, then a prefix carrying R/W=1. The bench builds this bus sequence bit by bit and confirms that the same prefix is NACKed after a STOP or on a fresh START. The majority filter is driven with a one-clock SCL dropout inside a high phase, and the received byte must come out unchanged.

// File: rtl/i2c_dual_addr_target.sv
module i2c_dual_addr_target #(
  parameter int SDA_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [9:0] own_addr_i,
  input  logic       ten_bit_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_next_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o
);

  localparam int HW = $clog2(SDA_HOLD + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TACK, S_IGN} st_t;
  typedef enum logic [1:0] {K_ADDR1, K_ADDR2, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h  <= '1; sda_h  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_q  <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[1:0], scl_sy[1]};
      sda_h  <= {sda_h[1:0], sda_sy[1]};
      scl_f  <= (scl_h[0] & scl_h[1]) | (scl_h[0] & scl_h[2]) | (scl_h[1] & scl_h[2]);
      sda_f  <= (sda_h[0] & sda_h[1]) | (sda_h[0] & sda_h[2]) | (sda_h[1] & sda_h[2]);
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  st_t         st;
  kind_t       kind;
  logic [3:0]  cnt;
  logic [7:0]  sr, txsr;
  logic        go_tx, hi_ok, nack, pend, pull;
  logic [HW-1:0] hold;

  wire rsvd7   = (own_addr_i[6:3] == 4'b0000) || (own_addr_i[6:3] == 4'b1111);
  wire hit7    = !ten_bit_i && !rsvd7 && (sr[7:1] == own_addr_i[6:0]);
  wire hit_pfx = ten_bit_i && (sr[7:3] == 5'b11110) && (sr[2:1] == own_addr_i[9:8]);
  wire hit_lo  = (sr == own_addr_i[7:0]);

  assign sda_pull_o = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR1; cnt <= '0; sr <= '0; txsr <= '0;
      go_tx <= 1'b0; hi_ok <= 1'b0; nack <= 1'b0; pend <= 1'b0; pull <= 1'b0;
      hold <= '0; rx_byte_o <= '0; rx_valid_o <= 1'b0; tx_next_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_next_o  <= 1'b0;
      if (hold != '0) begin
        hold <= hold - 1'b1;
        if (hold == HW'(1)) pull <= pend;
      end
      if (start_ev) begin
        st <= S_RX; kind <= K_ADDR1; cnt <= '0; pull <= 1'b0; hold <= '0;
      end else if (stop_ev) begin
        st <= S_IDLE; hi_ok <= 1'b0; pull <= 1'b0; hold <= '0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              hold <= HW'(SDA_HOLD);
              cnt  <= '0;
              case (kind)
                K_ADDR1: begin
                  if (hit7) begin
                    st <= S_ACK; pend <= 1'b1; go_tx <= sr[0]; kind <= K_DATA;
                  end else if (hit_pfx && !sr[0]) begin
                    st <= S_ACK; pend <= 1'b1; go_tx <= 1'b0; kind <= K_ADDR2; hi_ok <= 1'b0;
                  end else if (hit_pfx && sr[0] && hi_ok) begin
                    st <= S_ACK; pend <= 1'b1; go_tx <= 1'b1;
                  end else begin
                    st <= S_IGN; pend <= 1'b0; hi_ok <= 1'b0;
                  end
                end
                K_ADDR2: begin
                  if (hit_lo) begin
                    st <= S_ACK; pend <= 1'b1; go_tx <= 1'b0; kind <= K_DATA; hi_ok <= 1'b1;
                  end else begin
                    st <= S_IGN; pend <= 1'b0;
                  end
                end
                default: begin
                  rx_byte_o  <= sr;
                  rx_valid_o <= 1'b1;
                  st <= S_ACK; pend <= 1'b1; go_tx <= 1'b0;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              hold <= HW'(SDA_HOLD);
              cnt  <= '0;
              if (go_tx) begin
                st <= S_TX; txsr <= tx_byte_i; tx_next_o <= 1'b1; pend <= ~tx_byte_i[7];
              end else begin
                st <= S_RX; pend <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              hold <= HW'(SDA_HOLD);
              if (cnt == 4'd8) begin
                st <= S_TACK; pend <= 1'b0; cnt <= '0;
              end else begin
                txsr <= {txsr[6:0], 1'b0};
                pend <= ~txsr[6];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) nack <= sda_f;
            else if (scl_fall) begin
              hold <= HW'(SDA_HOLD);
              cnt  <= '0;
              if (nack) begin
                st <= S_IGN; pend <= 1'b0;
              end else begin
                st <= S_TX; txsr <= tx_byte_i; tx_next_o <= 1'b1; pend <= ~tx_byte_i[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_dual_addr_target_chk.sv
module i2c_dual_addr_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic rx_valid_o,
  input logic tx_next_o,
  input logic ignoring
);

  a_r11_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  a_r2_rx_pulse_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !scl_i);

  a_r2_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r5_txnext_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_next_o |-> !scl_i);

  a_r3_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_pull_o);

  a_r3_ignore_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !rx_valid_o);

endmodule

bind i2c_dual_addr_target i2c_dual_addr_target_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .sda_pull_o(sda_pull_o),
  .rx_valid_o(rx_valid_o),
  .tx_next_o(tx_next_o),
  .ignoring(st == S_IGN)
);

// File: tb/i2c_dual_addr_target_bench.sv
`timescale 1ns/1ps
module i2c_dual_addr_target_bench;

  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       ctrl_rel = 1'b1;
  logic       glitch = 1'b0;
  logic [9:0] own = 10'h052;
  logic       ten = 1'b0;
  logic [7:0] tx_byte;
  logic       sda_pull, tx_next, rx_valid;
  logic [7:0] rx_byte;
  wire        sda_line = ctrl_rel & ~sda_pull;

  int n_tests = 0, n_fail = 0;
  int rx_n = 0, tx_idx = 0, bad_moves = 0;
  logic [7:0] rx_log [0:31];

  always #10 clk = ~clk;

  function automatic logic [7:0] txv(input int i);
    return 8'(8'hA5 + i * 37);
  endfunction

  assign tx_byte = txv(tx_idx);

  i2c_dual_addr_target u_i2c_dual_addr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .own_addr_i(own), .ten_bit_i(ten),
    .tx_byte_i(tx_byte), .tx_next_o(tx_next),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  logic pull_q = 1'b0;
  always @(posedge clk) begin
    if (rx_valid) begin rx_log[rx_n % 32] <= rx_byte; rx_n <= rx_n + 1; end
    if (tx_next) tx_idx <= tx_idx + 1;
    if (rst_n && pull_q != sda_pull && scl) bad_moves <= bad_moves + 1;
    pull_q <= sda_pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bit_cycle(input logic val, output logic seen);
    ctrl_rel = val;
    wclk(Q);
    scl = 1'b1;
    if (glitch) begin
      wclk(Q / 2);
      scl = 1'b0; wclk(1); scl = 1'b1;
      wclk(Q - Q / 2 - 1);
    end else wclk(Q);
    @(negedge clk) seen = sda_line;
    wclk(Q);
    scl = 1'b0;
    wclk(Q);
  endtask

  task automatic bus_start;
    ctrl_rel = 1'b1; scl = 1'b1; wclk(Q);
    ctrl_rel = 1'b0; wclk(Q);
    scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_rstart;
    ctrl_rel = 1'b1; wclk(Q);
    scl = 1'b1; wclk(Q);
    ctrl_rel = 1'b0; wclk(Q);
    scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop;
    ctrl_rel = 1'b0; wclk(Q);
    scl = 1'b1; wclk(Q);
    ctrl_rel = 1'b1; wclk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, s); b[i] = s; end
    bit_cycle(!give_ack, s);
  endtask

  task automatic t_reset;
    chk("R1 pull after reset", sda_pull, 0);
    chk("R1 rx_valid after reset", rx_valid, 0);
  endtask

  task automatic t_write7;
    logic a; int base = rx_n;
    own = 10'h052; ten = 1'b0;
    bus_start;
    send_byte(8'hA4, a); chk("R2 address ack", a, 1);
    send_byte(8'h11, a); chk("R2 data ack 1", a, 1);
    send_byte(8'hEE, a); chk("R2 data ack 2", a, 1);
    bus_stop;
    chk("R2 byte count", rx_n - base, 2);
    chk("R2 first byte", rx_log[base % 32], 8'h11);
    chk("R2 second byte", rx_log[(base + 1) % 32], 8'hEE);
  endtask

  task automatic t_glitch;
    logic a; int base = rx_n;
    bus_start;
    send_byte(8'hA4, a); chk("R13 address ack", a, 1);
    glitch = 1'b1;
    send_byte(8'h6C, a);
    glitch = 1'b0;
    chk("R13 ack under glitch", a, 1);
    bus_stop;
    chk("R13 byte unchanged", rx_log[base % 32], 8'h6C);
  endtask

  task automatic t_mismatch7;
    logic a; int base = rx_n;
    bus_start;
    send_byte(8'hA6, a); chk("R3 wrong address nack", a, 0);
    send_byte(8'h00, a); chk("R3 later byte nack", a, 0);
    bus_stop;
    chk("R3 nothing received", rx_n - base, 0);
  endtask

  task automatic t_reserved;
    logic a;
    own = 10'h003;
    bus_start; send_byte(8'h06, a); bus_stop;
    chk("R4 0000xxx never matched", a, 0);
    own = 10'h07A;
    bus_start; send_byte(8'hF4, a); bus_stop;
    chk("R4 1111xxx never matched", a, 0);
    own = 10'h052;
  endtask

  task automatic t_read7;
    logic a; logic [7:0] b; int base_rx = rx_n; int base_tx = tx_idx;
    bus_start;
    send_byte(8'hA4, a); chk("R12 write address ack", a, 1);
    send_byte(8'h5A, a); chk("R12 data ack", a, 1);
    bus_rstart;
    send_byte(8'hA5, a); chk("R12 read address ack after Sr", a, 1);
    recv_byte(1'b1, b); chk("R5 first read byte", b, txv(base_tx));
    recv_byte(1'b0, b); chk("R5 second read byte", b, txv(base_tx + 1));
    chk("R5 tx_next pulses", tx_idx - base_tx, 2);
    recv_byte(1'b0, b); chk("R6 released after nack", b, 8'hFF);
    chk("R6 no further loads", tx_idx - base_tx, 2);
    bus_stop;
    chk("R12 write byte before Sr", rx_log[base_rx % 32], 8'h5A);
  endtask

  task automatic t_ten;
    logic a; logic [7:0] b; int base_rx; int base_tx;
    own = 10'h2B7; ten = 1'b1;
    base_rx = rx_n;
    bus_start;
    send_byte(8'hF4, a); chk("R7 prefix ack", a, 1);
    send_byte(8'hB7, a); chk("R7 low byte ack", a, 1);
    send_byte(8'h42, a); chk("R7 data ack", a, 1);
    chk("R7 data byte", rx_log[base_rx % 32], 8'h42);
    base_tx = tx_idx;
    bus_rstart;
    send_byte(8'hF5, a); chk("R9 read prefix after Sr ack", a, 1);
    recv_byte(1'b0, b); chk("R9 read byte", b, txv(base_tx));
    bus_stop;
    bus_start;
    send_byte(8'hF5, a); chk("R10 read prefix after STOP nack", a, 0);
    bus_stop;
    bus_start;
    send_byte(8'hF2, a); chk("R7 wrong prefix bits nack", a, 0);
    bus_stop;
    base_rx = rx_n;
    bus_start;
    send_byte(8'hF4, a); chk("R8 prefix ack", a, 1);
    send_byte(8'hB8, a); chk("R8 low byte mismatch nack", a, 0);
    send_byte(8'h33, a); chk("R8 data ignored", a, 0);
    bus_rstart;
    send_byte(8'hF5, a); chk("R9 read without full selection nack", a, 0);
    bus_stop;
    chk("R8 nothing received", rx_n - base_rx, 0);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(10);
    t_reset;
    t_write7;
    t_glitch;
    t_mismatch7;
    t_reserved;
    t_read7;
    t_ten;
    chk("R11 pull moved while SCL high", bad_moves, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wclk(180000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule